// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Address-Frame Filtering

This block receives asynchronous serial frames on a bus shared by several nodes. Each frame has a start bit, eight data bits sent least significant bit first, one extra flag bit and one stop bit. The flag bit marks the frame as an address (node ID) when it is 1, or as payload when it is 0. The line is sampled at sixteen times the bit rate, and each bit is decided by a two-out-of-three vote over the samples around its centre. The bit-rate tick comes from outside the block.

Host software reads each address frame and compares the ID with its own. If they differ, it clears the data-accept flag in the control register. Payload frames are then dropped silently: no strobe, no interrupt and no error check. Address frames are always delivered. The receiver keeps tracking start bits while payload is being dropped, so it never misses the next address frame.

Two write rules protect the control register. The accept flag can only be cleared while both the power bit and the receive-enable bit are set. The bit that routes errors to the completion interrupt can only be changed while the transmit-enable bit is clear.

Top module: `mpuart_rx`

## Requirements
- R1: After reset, `ctl_q` reads 5'b10000: the accept flag (bit 4) is set, and power (bit 0), receive enable (bit 1), transmit enable (bit 2) and error routing (bit 3) are clear. Both error flags, `rx_valid` and both interrupts are low.
- R2: A frame is received only while `ctl_q` bits 0 and 1 are both 1. The frame is a low start bit, 8 data bits LSB first, a flag bit and a stop bit, each 16 ticks of `baud_tick` long. A delivered frame shows its byte on `rx_data` and its flag bit on `rx_mpb`.
- R3: With the accept flag at 1, every completed payload frame is delivered with a one-cycle `rx_valid` and a one-cycle `irq_rx`.
- R4: With the accept flag at 0, a payload frame (flag bit 0) causes no `rx_valid`, no interrupt and no error flag, even if its stop bit is low. `rx_data` keeps its previous value.
- R5: An address frame (flag bit 1) is always delivered and raises `irq_rx`, whatever the accept flag holds. This includes an address frame that directly follows a dropped payload frame.
- R6: A delivered frame whose stop bit samples low sets `err_frame`. This applies to an address frame received while the accept flag is 0.
- R7: A delivered frame that completes while the previous delivered byte has not been read with `data_rd` sets `err_overrun`, and its byte replaces the stored one.
- R8: A one-cycle `stat_rd` clears both error flags. If a new error arrives in the same cycle, the new error wins.
- R9: A write that clears the accept flag takes effect only if power and receive enable are both 1 before the write. Otherwise the flag stays 1.
- R10: A write to the error-routing bit (bit 3) takes effect only if transmit enable is 0 before the write. Otherwise the routing bit keeps its value.
- R11: On a delivered frame with an error, `irq_err` pulses when the routing bit is 0, and `irq_rx` pulses instead when it is 1. The two interrupts never pulse together.
- R12: A low pulse shorter than half a bit is rejected as a false start. Every `rx_valid`, `irq_rx` and `irq_err` pulse lasts exactly one cycle.
- R13: While receive enable is 0, frames on `rxd` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write value {accept, route, txe, rxe, power} |
| stat_rd | input | 1 | Status read, clears error flags |
| data_rd | input | 1 | Data read, marks the byte as taken |
| ctl_q | output | 5 | Control register contents |
| rx_data | output | 8 | Last delivered byte |
| rx_mpb | output | 1 | Flag bit of the last delivered frame |
| rx_valid | output | 1 | Delivery strobe |
| irq_rx | output | 1 | Receive-complete interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
The bench sends a payload frame with a bad stop bit while payload is being dropped. A design that checks errors before applying the filter would raise `irq_err` or `err_frame` on a frame nobody asked for. It then sends a bad address frame under the same setting, to catch a design that filters address frames as well and so hides errors the host needs. The control write rules are exercised with illegal writes, including one write that clears transmit enable and sets the routing bit together. A design that decides on the new register values instead of the old ones would accept that write. A short glitch followed by a good frame shows whether the receiver locks onto noise and then garbles the real byte.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  localparam int CTL_W   = 5;
  localparam int CTL_PWR = 0;
  localparam int CTL_RXE = 1;
  localparam int CTL_TXE = 2;
  localparam int CTL_RTE = 3;
  localparam int CTL_ACC = 4;
  localparam logic [CTL_W-1:0] CTL_RESET = 5'b10000;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BITS  = 2'd2,
    PH_STOP  = 2'd3
  } rx_phase_e;
endpackage

// File: rtl/mpuart_ctlreg.sv
module mpuart_ctlreg
  import mpuart_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] ctl_o
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             clr_ok;

  always_comb begin
    ctl_d  = ctl_q;
    clr_ok = ctl_q[CTL_PWR] & ctl_q[CTL_RXE];
    if (wr_i) begin
      ctl_d[CTL_PWR] = wdata_i[CTL_PWR];
      ctl_d[CTL_RXE] = wdata_i[CTL_RXE];
      ctl_d[CTL_TXE] = wdata_i[CTL_TXE];
      // routing bit changes only while the transmitter is off
      if (!ctl_q[CTL_TXE]) ctl_d[CTL_RTE] = wdata_i[CTL_RTE];
      // accept flag can be cleared only when the receiver is powered and enabled
      if (wdata_i[CTL_ACC])  ctl_d[CTL_ACC] = 1'b1;
      else if (clr_ok)       ctl_d[CTL_ACC] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/mpuart_bitsampler.sv
module mpuart_bitsampler
  import mpuart_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_on_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o,
  output logic              stop_ok_o
);
  localparam int CW   = $clog2(OSR);
  localparam int NB   = DATA_W + 1;
  localparam int IW   = $clog2(NB + 1);
  localparam int MID  = OSR / 2;

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_phase_e     ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [NB-1:0] sh_q, sh_d;
  logic [1:0]    smp_q, smp_d;
  logic          done_q, done_d;
  logic          stop_q, stop_d;
  logic          vote, at_vote, at_last;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd_i};
  end

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    smp_d   = smp_q;
    stop_d  = stop_q;
    done_d  = 1'b0;
    vote    = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx_s) | (smp_q[1] & rx_s);
    at_vote = (cnt_q == CW'(MID + 1));
    at_last = (cnt_q == CW'(OSR - 1));
    if (!rx_on_i) begin
      ph_d = PH_IDLE;
    end else if (tick_i) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
      if (cnt_q == CW'(MID - 1)) smp_d[0] = rx_s;
      if (cnt_q == CW'(MID))     smp_d[1] = rx_s;
      unique case (ph_q)
        PH_IDLE: begin
          cnt_d = CW'(1);
          if (!rx_s) ph_d = PH_START;
        end
        PH_START: begin
          if (at_vote && vote) ph_d = PH_IDLE;
          else if (at_last) begin
            ph_d  = PH_BITS;
            idx_d = '0;
          end
        end
        PH_BITS: begin
          if (at_vote) sh_d = {vote, sh_q[NB-1:1]};
          if (at_last) begin
            if (idx_q == IW'(NB - 1)) ph_d = PH_STOP;
            else                      idx_d = idx_q + 1'b1;
          end
        end
        PH_STOP: begin
          if (at_vote) begin
            done_d = 1'b1;
            stop_d = vote;
            ph_d   = PH_IDLE;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      smp_q  <= 2'b11;
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      smp_q  <= smp_d;
      done_q <= done_d;
      stop_q <= stop_d;
    end
  end

  assign done_o    = done_q;
  assign data_o    = sh_q[DATA_W-1:0];
  assign mpb_o     = sh_q[NB-1];
  assign stop_ok_o = stop_q;
endmodule

// File: rtl/mpuart_report.sv
module mpuart_report #(
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mpb_i,
  input  logic              stop_ok_i,
  input  logic              accept_i,
  input  logic              route_i,
  input  logic              data_rd_i,
  input  logic              stat_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o,
  output logic              valid_o,
  output logic              irq_rx_o,
  output logic              irq_err_o,
  output logic              fe_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] data_q, data_d;
  logic mpb_q, mpb_d, valid_q, valid_d, irx_q, irx_d, ier_q, ier_d;
  logic fe_q, fe_d, oe_q, oe_d, unread_q, unread_d;
  logic deliver, fe_now, oe_now, err_now;

  always_comb begin
    deliver  = done_i & (mpb_i | accept_i);
    fe_now   = deliver & ~stop_ok_i;
    oe_now   = deliver & unread_q & ~data_rd_i;
    err_now  = fe_now | oe_now;
    data_d   = deliver ? data_i : data_q;
    mpb_d    = deliver ? mpb_i  : mpb_q;
    valid_d  = deliver;
    irx_d    = deliver & (~err_now | route_i);
    ier_d    = err_now & ~route_i;
    fe_d     = stat_rd_i ? 1'b0 : fe_q;
    oe_d     = stat_rd_i ? 1'b0 : oe_q;
    if (fe_now) fe_d = 1'b1;
    if (oe_now) oe_d = 1'b1;
    unread_d = deliver ? 1'b1 : (data_rd_i ? 1'b0 : unread_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      mpb_q    <= 1'b0;
      valid_q  <= 1'b0;
      irx_q    <= 1'b0;
      ier_q    <= 1'b0;
      fe_q     <= 1'b0;
      oe_q     <= 1'b0;
      unread_q <= 1'b0;
    end else begin
      data_q   <= data_d;
      mpb_q    <= mpb_d;
      valid_q  <= valid_d;
      irx_q    <= irx_d;
      ier_q    <= ier_d;
      fe_q     <= fe_d;
      oe_q     <= oe_d;
      unread_q <= unread_d;
    end
  end

  assign data_o    = data_q;
  assign mpb_o     = mpb_q;
  assign valid_o   = valid_q;
  assign irq_rx_o  = irx_q;
  assign irq_err_o = ier_q;
  assign fe_o      = fe_q;
  assign oe_o      = oe_q;
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpuart_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_valid,
  output logic              irq_rx,
  output logic              irq_err,
  output logic              err_frame,
  output logic              err_overrun
);
  logic              frm_done, frm_mpb, frm_stop_ok, rx_on;
  logic [DATA_W-1:0] frm_data;

  mpuart_ctlreg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ctl_wr),
    .wdata_i (ctl_wdata),
    .ctl_o   (ctl_q)
  );

  assign rx_on = ctl_q[CTL_PWR] & ctl_q[CTL_RXE];

  mpuart_bitsampler #(.OSR(OSR), .DATA_W(DATA_W)) u_smp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_on_i   (rx_on),
    .tick_i    (baud_tick),
    .rxd_i     (rxd),
    .done_o    (frm_done),
    .data_o    (frm_data),
    .mpb_o     (frm_mpb),
    .stop_ok_o (frm_stop_ok)
  );

  mpuart_report #(.DATA_W(DATA_W)) u_rep (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (frm_done),
    .data_i    (frm_data),
    .mpb_i     (frm_mpb),
    .stop_ok_i (frm_stop_ok),
    .accept_i  (ctl_q[CTL_ACC]),
    .route_i   (ctl_q[CTL_RTE]),
    .data_rd_i (data_rd),
    .stat_rd_i (stat_rd),
    .data_o    (rx_data),
    .mpb_o     (rx_mpb),
    .valid_o   (rx_valid),
    .irq_rx_o  (irq_rx),
    .irq_err_o (irq_err),
    .fe_o      (err_frame),
    .oe_o      (err_overrun)
  );
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk
  import mpuart_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stat_rd,
  input logic [CTL_W-1:0] ctl_q,
  input logic             rx_valid,
  input logic             rx_mpb,
  input logic             irq_rx,
  input logic             irq_err,
  input logic             err_frame,
  input logic             err_overrun
);
  a_r4_payload_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_mpb |-> $past(ctl_q[CTL_ACC]));
  a_r8_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (!err_frame && !err_overrun) || rx_valid);
  a_r9_accept_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_q[CTL_PWR] && ctl_q[CTL_RXE]) && ctl_q[CTL_ACC] |=> ctl_q[CTL_ACC]);
  a_r10_route_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_TXE] |=> $stable(ctl_q[CTL_RTE]));
  a_r11_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx && irq_err));
  a_r11_err_route: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> !$past(ctl_q[CTL_RTE]));
  a_r12_irq_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx || irq_err) |-> rx_valid);
  a_r12_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx || irq_err) |=> !(irq_rx || irq_err));
endmodule

bind mpuart_rx mpuart_rx_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .stat_rd     (stat_rd),
  .ctl_q       (ctl_q),
  .rx_valid    (rx_valid),
  .rx_mpb      (rx_mpb),
  .irq_rx      (irq_rx),
  .irq_err     (irq_err),
  .err_frame   (err_frame),
  .err_overrun (err_overrun)
);

// File: tb/mpuart_rx_tb_top.sv
`timescale 1ns/1ps
module mpuart_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       rxd = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [4:0] ctl_q;
  logic [7:0] rx_data;
  logic       rx_mpb, rx_valid, irq_rx, irq_err, err_frame, err_overrun;

  int checks = 0;
  int errors = 0;
  int n_valid = 0, n_irx = 0, n_ierr = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mpuart_rx dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_rd(stat_rd), .data_rd(data_rd),
    .ctl_q(ctl_q), .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_valid(rx_valid),
    .irq_rx(irq_rx), .irq_err(irq_err), .err_frame(err_frame), .err_overrun(err_overrun)
  );

  always @(negedge clk) begin
    if (rx_valid) n_valid++;
    if (irq_rx)   n_irx++;
    if (irq_err)  n_ierr++;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [4:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic pulse_rd(bit stat, bit dat);
    @(negedge clk); stat_rd = stat; data_rd = dat;
    @(negedge clk); stat_rd = 1'b0; data_rd = 1'b0;
  endtask

  task automatic send_frame(logic [7:0] d, logic mpb, logic stop);
    logic [10:0] bits;
    bits = {stop, mpb, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); rxd = bits[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "ctl_q", ctl_q, 5'h10);
    chk("R1", "flags", {err_frame, err_overrun, rx_valid, irq_rx, irq_err}, 0);
  endtask

  task automatic t_accept_data();
    int v0, i0, e0;
    wr_ctl(5'h13);
    v0 = n_valid; i0 = n_irx; e0 = n_ierr;
    send_frame(8'hA5, 1'b0, 1'b1);
    chk("R3", "valid pulses", n_valid - v0, 1);
    chk("R3", "irq_rx pulses", n_irx - i0, 1);
    chk("R2", "rx_data", rx_data, 8'hA5);
    chk("R2", "rx_mpb", rx_mpb, 0);
    chk("R3", "irq_err pulses", n_ierr - e0, 0);
    pulse_rd(1'b0, 1'b1);
  endtask

  task automatic t_drop_then_address();
    int v0, i0, e0;
    wr_ctl(5'h03);
    chk("R9", "accept cleared when allowed", ctl_q, 5'h03);
    v0 = n_valid; i0 = n_irx; e0 = n_ierr;
    send_frame(8'h5A, 1'b0, 1'b0);
    chk("R4", "valid on dropped", n_valid - v0, 0);
    chk("R4", "irq on dropped", (n_irx - i0) + (n_ierr - e0), 0);
    chk("R4", "error flags", {err_frame, err_overrun}, 0);
    chk("R4", "rx_data kept", rx_data, 8'hA5);
    send_frame(8'h3C, 1'b1, 1'b1);
    chk("R5", "addr valid", n_valid - v0, 1);
    chk("R5", "addr irq_rx", n_irx - i0, 1);
    chk("R5", "addr data", {rx_mpb, rx_data}, 9'h13C);
    pulse_rd(1'b0, 1'b1);
  endtask

  task automatic t_addr_error();
    int i0, e0;
    i0 = n_irx; e0 = n_ierr;
    send_frame(8'h77, 1'b1, 1'b0);
    chk("R6", "err_frame", err_frame, 1);
    chk("R6", "irq_err", n_ierr - e0, 1);
    chk("R11", "irq_rx on error, route 0", n_irx - i0, 0);
    pulse_rd(1'b1, 1'b1);
    chk("R8", "flags after status read", {err_frame, err_overrun}, 0);
  endtask

  task automatic t_overrun();
    int e0;
    wr_ctl(5'h13);
    send_frame(8'h11, 1'b0, 1'b1);
    chk("R7", "no overrun on first", err_overrun, 0);
    e0 = n_ierr;
    send_frame(8'h22, 1'b0, 1'b1);
    chk("R7", "overrun", err_overrun, 1);
    chk("R7", "overrun irq", n_ierr - e0, 1);
    chk("R7", "newer byte kept", rx_data, 8'h22);
    pulse_rd(1'b1, 1'b1);
  endtask

  task automatic t_locks();
    wr_ctl(5'h10);
    wr_ctl(5'h00);
    chk("R9", "accept held while off", ctl_q, 5'h10);
    wr_ctl(5'h17);
    wr_ctl(5'h1F);
    chk("R10", "route blocked by txe", ctl_q, 5'h17);
    wr_ctl(5'h1B);
    chk("R10", "txe clear same write", ctl_q, 5'h13);
    wr_ctl(5'h1B);
    chk("R10", "route accepted", ctl_q, 5'h1B);
  endtask

  task automatic t_route();
    int i0, e0;
    i0 = n_irx; e0 = n_ierr;
    send_frame(8'h44, 1'b0, 1'b0);
    chk("R11", "irq_rx on error, route 1", n_irx - i0, 1);
    chk("R11", "irq_err, route 1", n_ierr - e0, 0);
    chk("R11", "err_frame", err_frame, 1);
    pulse_rd(1'b1, 1'b1);
    wr_ctl(5'h13);
  endtask

  task automatic t_glitch();
    int v0;
    v0 = n_valid;
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    chk("R12", "glitch ignored", n_valid - v0, 0);
    send_frame(8'h99, 1'b0, 1'b1);
    chk("R12", "frame after glitch", n_valid - v0, 1);
    chk("R12", "data after glitch", rx_data, 8'h99);
    pulse_rd(1'b0, 1'b1);
  endtask

  task automatic t_disabled();
    int v0;
    wr_ctl(5'h11);
    v0 = n_valid;
    send_frame(8'h55, 1'b1, 1'b1);
    chk("R13", "no valid while disabled", n_valid - v0, 0);
    chk("R13", "rx_data kept", rx_data, 8'h99);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_accept_data();
    t_drop_then_address();
    t_addr_error();
    t_overrun();
    t_locks();
    t_route();
    t_glitch();
    t_disabled();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule